// File: doc/BRIEF.md
# Three-Phase Complementary PWM with Dead-Time Gap

This block drives three motor phases, each with a positive and a negative switch output. A shared triangle counter sweeps up and back down. Each phase compares its duty value against the counter to form a compare wave, and compares it against an offset threshold to form a dead-time wave. Each output is the AND of one compare phase with the opposite dead-time phase. As a result the two switches of a phase can never be on together. At every switching edge both switches are off for twice the programmed dead time.

Software writes the period, the dead time, three duty buffers and a control word through a simple write port. A new duty value sits in its buffer and reaches the comparators only when the counter turns at its crest or trough, so no period is cut short. Polarity bits set each side to active-high or active-low. An external clear input restarts the counter, but only when clearing is enabled in the control word.

Top module: `cpwm_core`

## Requirements
- R1: After reset the period, dead time, duties and control word are zero, so the block is stopped with both polarity bits at active-low, and all six outputs read 1.
- R2: While the run bit (control bit 0) is 0, every output sits at the inverse of its side's polarity bit, and the counter is held at its start value (the dead time).
- R3: Control bit 1 sets the polarity of `pwm_p` and control bit 2 sets that of `pwm_n`. A bit value of 1 means active-high and 0 means active-low.
- R4: A duty of 0 keeps the positive output of that phase active on every cycle, and its negative output is never active.
- R5: A duty greater than the period keeps the positive output permanently inactive. A duty equal to the period makes it active for exactly one cycle in each full sweep.
- R6: While running, the counter sweeps from T up to P+T and back down to T, one step per cycle, so a full sweep takes 2·P cycles (P = period, T = dead time, D = duty). In one sweep the positive output is active on the cycles where the counter is at or above D+T, and the negative output on the cycles where counter+T is below D.
- R7: On no cycle are the positive and negative outputs of the same phase both active.
- R8: When the positive output of a phase turns off, both outputs of that phase stay inactive for exactly 2·T cycles before the negative output turns on.
- R9: A duty written while running reaches the comparators only at the next crest or trough of the counter. Until then the outputs follow the previous duty.
- R10: When control bit 3 is 1, a high `ext_clr` resets the counter to its start value and up-direction on the next edge, and holding it high holds the counter there. When control bit 3 is 0, `ext_clr` has no effect.
- R11: The write addresses are 0 for the period, 1 for the dead time, 2, 3 and 4 for the duties of phases 0, 1 and 2, and 5 for the control word. Each phase uses only its own duty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| ext_clr | input | 1 | External counter clear request |
| pwm_p | output | 3 | Positive-side outputs, one per phase |
| pwm_n | output | 3 | Negative-side outputs, one per phase |

## Verification
The hardest case to reach is a duty change that arrives in the middle of a sweep. To show the transfer is deferred, the write must land after a switching edge and before the next trough. The bench waits, at the outputs alone, for the positive output of phase 0 to fall on the down slope. It then writes duty 0 at once and checks that the output stays off until the trough, where it turns fully on. The 2·T gap is measured the same way: the bench counts the both-off cycles between the positive fall and the negative rise.

// File: rtl/cpwm_pkg.sv
// Package: register addresses and control word layout for the PWM block.
// Assumes a 3-bit register address space; the control word is 4 bits.
package cpwm_pkg;
    localparam int ADDR_W = 3;
    localparam logic [ADDR_W-1:0] A_PERIOD = 3'd0;
    localparam logic [ADDR_W-1:0] A_DEAD   = 3'd1;
    localparam logic [ADDR_W-1:0] A_DUTY0  = 3'd2;
    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd5;

    // Control word, bit 0 is run, bit 3 is clear enable.
    typedef struct packed {
        logic clr_en;
        logic pol_n;
        logic pol_p;
        logic run;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/cpwm_regs.sv
// Module: register bank holding period, dead time, per-phase duty buffers
// and the control word. Assumes single-cycle writes; all registers clear
// to zero on reset.
module cpwm_regs
    import cpwm_pkg::*;
#(
    parameter int CW  = 16,
    parameter int NPH = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [CW-1:0]             wr_data,
    output logic [CW-1:0]             period,
    output logic [CW-1:0]             dead,
    output logic [NPH-1:0][CW-1:0]    duty_buf,
    output ctrl_t                     ctrl
);
    // Period, dead time and control word updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period <= '0;
            dead   <= '0;
            ctrl   <= '0;
        end else if (wr_en) begin
            if (wr_addr == A_PERIOD) period <= wr_data;
            if (wr_addr == A_DEAD)   dead   <= wr_data;
            if (wr_addr == A_CTRL)   ctrl   <= ctrl_t'(wr_data[CTRL_W-1:0]);
        end
    end

    // One duty buffer per phase at consecutive addresses.
    for (genvar i = 0; i < NPH; i++) begin : g_buf
        localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(A_DUTY0 + i);
        // Capture this phase's duty buffer on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                duty_buf[i] <= '0;
            else if (wr_en && wr_addr == MY_ADDR)
                duty_buf[i] <= wr_data;
        end
    end
endmodule

// File: rtl/cpwm_tri_cnt.sv
// Module: shared up/down triangle counter. Sweeps from 'bottom' to
// bottom+span and back, one step per cycle. Holds at 'bottom' while
// stopped or cleared, or when span is zero. 'turn' marks the cycles on
// which duty buffers may be transferred (crest, trough, stopped, cleared).
module cpwm_tri_cnt #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          clr,
    input  logic [CW-1:0] bottom,
    input  logic [CW-1:0] span,
    output logic [CW:0]   cnt,
    output logic          turn
);
    logic          up;
    logic [CW:0]   bot_x;
    logic [CW:0]   top_x;
    logic          at_top;
    logic          at_bot;
    logic          flat;

    // Derive sweep limits and turning conditions.
    always_comb begin
        bot_x  = {1'b0, bottom};
        top_x  = bot_x + {1'b0, span};
        flat   = (span == '0);
        at_top = up && (cnt >= top_x);
        at_bot = !up && (cnt <= bot_x);
        turn   = !run || clr || at_top || at_bot;
    end

    // Advance the counter and its direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            up  <= 1'b1;
        end else if (!run || clr || flat) begin
            cnt <= bot_x;
            up  <= 1'b1;
        end else if (at_top) begin
            cnt <= cnt - 1'b1;
            up  <= 1'b0;
        end else if (at_bot) begin
            cnt <= cnt + 1'b1;
            up  <= 1'b1;
        end else if (up) begin
            cnt <= cnt + 1'b1;
        end else begin
            cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/cpwm_phase.sv
// Module: one phase. Holds the active duty, builds the compare and
// dead-time waves from the shared counter, ANDs them into non-overlapping
// output waves and applies polarity. Assumes the counter is no wider than
// CW+1 bits and that 'load' is high only at sweep turns or while stopped.
module cpwm_phase #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] buf_duty,
    input  logic [CW-1:0] dead,
    input  logic [CW:0]   cnt,
    input  logic          run,
    input  logic          pol_p,
    input  logic          pol_n,
    output logic [CW-1:0] act_duty,
    output logic          pin_p,
    output logic          pin_n
);
    localparam int XW = CW + 2;

    logic [XW-1:0] duty_x;
    logic [XW-1:0] dead_x;
    logic [XW-1:0] cnt_x;
    logic          cmp_a;
    logic          cmp_b;
    logic          dtw_a;
    logic          dtw_b;
    logic          og_a;
    logic          og_b;

    // Transfer the buffered duty only on load cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)
            act_duty <= '0;
        else if (load)
            act_duty <= buf_duty;
    end

    // Compare, dead-time and output-generation waves with polarity.
    always_comb begin
        duty_x = {2'b00, act_duty};
        dead_x = {2'b00, dead};
        cnt_x  = {1'b0, cnt};
        cmp_a  = cnt_x >= (duty_x + dead_x);
        cmp_b  = !cmp_a;
        dtw_b  = (cnt_x + dead_x) >= duty_x;
        dtw_a  = !dtw_b;
        og_a   = run && cmp_a && dtw_b;
        og_b   = run && cmp_b && dtw_a;
        pin_p  = pol_p ? og_a : !og_a;
        pin_n  = pol_n ? og_b : !og_b;
    end
endmodule

// File: rtl/cpwm_core.sv
// Module: top of the three-phase complementary PWM. Ties the register
// bank, the shared triangle counter and one phase unit per output pair.
// Assumes synchronous active-low reset and a single clock domain;
// ext_clr is already synchronous to clk.
module cpwm_core
    import cpwm_pkg::*;
#(
    parameter int CW  = 16,
    parameter int NPH = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [CW-1:0]      wr_data,
    input  logic               ext_clr,
    output logic [NPH-1:0]     pwm_p,
    output logic [NPH-1:0]     pwm_n
);
    logic [CW-1:0]           period;
    logic [CW-1:0]           dead;
    logic [NPH-1:0][CW-1:0]  duty_buf;
    logic [NPH-1:0][CW-1:0]  act_duty;
    ctrl_t                   ctrl;
    logic                    run;
    logic                    pol_p;
    logic                    pol_n;
    logic                    clr_en;
    logic                    clr_hit;
    logic [CW:0]             cnt;
    logic                    turn;

    // Unpack control fields and qualify the external clear.
    always_comb begin
        run     = ctrl.run;
        pol_p   = ctrl.pol_p;
        pol_n   = ctrl.pol_n;
        clr_en  = ctrl.clr_en;
        clr_hit = run && clr_en && ext_clr;
    end

    cpwm_regs #(.CW(CW), .NPH(NPH)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .period   (period),
        .dead     (dead),
        .duty_buf (duty_buf),
        .ctrl     (ctrl)
    );

    cpwm_tri_cnt #(.CW(CW)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .clr    (clr_hit),
        .bottom (dead),
        .span   (period),
        .cnt    (cnt),
        .turn   (turn)
    );

    for (genvar i = 0; i < NPH; i++) begin : g_ph
        cpwm_phase #(.CW(CW)) u_ph (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (turn),
            .buf_duty (duty_buf[i]),
            .dead     (dead),
            .cnt      (cnt),
            .run      (run),
            .pol_p    (pol_p),
            .pol_n    (pol_n),
            .act_duty (act_duty[i]),
            .pin_p    (pwm_p[i]),
            .pin_n    (pwm_n[i])
        );
    end
endmodule

// File: rtl/cpwm_checker.sv
// Module: protocol checker for cpwm_core, attached by bind. Observes
// pins, control fields, the counter and the active duties.
module cpwm_checker #(
    parameter int CW  = 16,
    parameter int NPH = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   run,
    input  logic                   pol_p,
    input  logic                   pol_n,
    input  logic                   clr_en,
    input  logic                   ext_clr,
    input  logic [CW-1:0]          period,
    input  logic [CW-1:0]          dead,
    input  logic [CW:0]            cnt,
    input  logic                   turn,
    input  logic [NPH-1:0][CW-1:0] act_duty,
    input  logic [NPH-1:0]         pwm_p,
    input  logic [NPH-1:0]         pwm_n
);
    // R2: stopped block shows inactive levels on every pin.
    assert_idle_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (pwm_p == {NPH{!pol_p}}) && (pwm_n == {NPH{!pol_n}}));

    // R10: enabled external clear parks the counter at its start value.
    assert_clear_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (run && clr_en && ext_clr) |=> (cnt == {1'b0, $past(dead)}));

    for (genvar i = 0; i < NPH; i++) begin : g_chk
        // R7: the two switches of a phase are never active together.
        assert_no_overlap_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !((pwm_p[i] == pol_p) && (pwm_n[i] == pol_n)));

        // R9: active duty only changes after a turn cycle.
        assert_load_at_turn_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (act_duty[i] != $past(act_duty[i])) |-> $past(turn));

        // R4: zero duty means positive output always active.
        assert_full_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (run && act_duty[i] == '0) |-> (pwm_p[i] == pol_p));

        // R5: duty above period means positive output never active.
        assert_full_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (run && act_duty[i] > period) |-> (pwm_p[i] != pol_p));
    end
endmodule

bind cpwm_core cpwm_checker #(.CW(CW), .NPH(NPH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .pol_p    (pol_p),
    .pol_n    (pol_n),
    .clr_en   (clr_en),
    .ext_clr  (ext_clr),
    .period   (period),
    .dead     (dead),
    .cnt      (cnt),
    .turn     (turn),
    .act_duty (act_duty),
    .pwm_p    (pwm_p),
    .pwm_n    (pwm_n)
);

// File: tb/cpwm_core_test.sv
// Directed bench for cpwm_core: one task per scenario, each checking itself.
module cpwm_core_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        ext_clr = 1'b0;
    logic [2:0]  pwm_p;
    logic [2:0]  pwm_n;

    int  vec = 0;
    int  bad = 0;
    int  overlap_cnt = 0;
    bit  mon_on = 1'b0;
    bit  done = 1'b0;
    bit  pp_s = 1'b0;
    bit  pn_s = 1'b0;

    always #5 clk = !clk;

    cpwm_core uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .ext_clr (ext_clr),
        .pwm_p   (pwm_p),
        .pwm_n   (pwm_n)
    );

    // R7 monitor: sampled 2 ns after each rising edge.
    always @(posedge clk) begin
        #2;
        if (mon_on && rst_n) begin
            for (int i = 0; i < 3; i++)
                if (pwm_p[i] == pp_s && pwm_n[i] == pn_s) overlap_cnt++;
        end
    end

    task automatic check(string req, string what, int act, int exp);
        vec++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = 16'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // R11: control word at address 5, bits {clr_en, pol_n, pol_p, run}.
    task automatic set_ctrl(bit run, bit pp, bit pn, bit ce);
        mon_on = 1'b0;
        wr(5, {ce, pn, pp, run});
        pp_s = pp; pn_s = pn;
        @(negedge clk);
        mon_on = 1'b1;
    endtask

    // Expected positive / negative active cycles per sweep (R6).
    function automatic int exp_pos(int d, int p, int t);
        int n = 0;
        for (int k = 0; k < 2 * p; k++) begin
            int v = t + ((k <= p) ? k : 2 * p - k);
            if (v >= d + t) n++;
        end
        return n;
    endfunction

    function automatic int exp_neg(int d, int p, int t);
        int n = 0;
        for (int k = 0; k < 2 * p; k++) begin
            int v = t + ((k <= p) ? k : 2 * p - k);
            if (v + t < d) n++;
        end
        return n;
    endfunction

    task automatic measure(input int ph, input int n, output int pc, output int nc);
        pc = 0; nc = 0;
        repeat (n) begin
            @(negedge clk);
            if (pwm_p[ph] == pp_s) pc++;
            if (pwm_n[ph] == pn_s) nc++;
        end
    endtask

    task automatic t_reset();
        check("R1", "pwm_p after reset", int'(pwm_p), 7);
        check("R1", "pwm_n after reset", int'(pwm_n), 7);
    endtask

    task automatic t_idle_polarity();
        set_ctrl(0, 1, 0, 0);
        check("R2", "idle pwm_p, pol_p=1", int'(pwm_p), 0);
        check("R3", "idle pwm_n, pol_n=0", int'(pwm_n), 7);
        set_ctrl(0, 0, 1, 0);
        check("R2", "idle pwm_p, pol_p=0", int'(pwm_p), 7);
        check("R3", "idle pwm_n, pol_n=1", int'(pwm_n), 0);
    endtask

    task automatic t_mid_duties();
        int pc, nc;
        int d[3] = '{20, 10, 30};
        wr(0, 40); wr(1, 3);
        wr(2, d[0]); wr(3, d[1]); wr(4, d[2]);
        overlap_cnt = 0;
        set_ctrl(1, 1, 1, 0);
        repeat (90) @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            measure(i, 80, pc, nc);
            check("R6", $sformatf("pos count phase %0d", i), pc, exp_pos(d[i], 40, 3));
            check("R11", $sformatf("neg count phase %0d", i), nc, exp_neg(d[i], 40, 3));
        end
        check("R7", "overlap cycles, mid duties", overlap_cnt, 0);
    endtask

    task automatic gap_measure(input int ph, output int g);
        bit prev = 1'b0;
        bit cur;
        g = -1;
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            cur = (pwm_p[ph] == pp_s);
            if (prev && !cur) begin
                g = 0;
                while (pwm_n[ph] != pn_s && g < 400) begin
                    g++;
                    @(negedge clk);
                end
                break;
            end
            prev = cur;
        end
    endtask

    task automatic t_gap();
        int g;
        gap_measure(0, g);
        check("R8", "gap with dead time 3", g, 6);
        set_ctrl(0, 1, 1, 0);
        wr(1, 0);
        set_ctrl(1, 1, 1, 0);
        repeat (90) @(negedge clk);
        gap_measure(0, g);
        check("R8", "gap with dead time 0", g, 0);
        set_ctrl(0, 1, 1, 0);
        wr(1, 3);
        set_ctrl(1, 1, 1, 0);
        repeat (90) @(negedge clk);
    endtask

    task automatic t_extremes();
        int pc, nc;
        wr(2, 0); wr(3, 40); wr(4, 41);
        overlap_cnt = 0;
        repeat (90) @(negedge clk);
        measure(0, 80, pc, nc);
        check("R4", "duty 0 pos count", pc, 80);
        check("R4", "duty 0 neg count", nc, 0);
        measure(1, 80, pc, nc);
        check("R5", "duty = period pos count", pc, 1);
        measure(2, 80, pc, nc);
        check("R5", "duty > period pos count", pc, 0);
        check("R7", "overlap cycles, extremes", overlap_cnt, 0);
    endtask

    task automatic t_active_low();
        int pc, nc;
        set_ctrl(1, 0, 0, 0);
        measure(0, 80, pc, nc);
        check("R3", "active-low duty 0 pos active count", pc, 80);
        check("R3", "active-low pwm_p[0] level", int'(pwm_p[0]), 0);
        check("R3", "active-low pwm_n[0] level", int'(pwm_n[0]), 1);
        set_ctrl(1, 1, 1, 0);
    endtask

    task automatic t_buffer_transfer();
        bit prev = 1'b0;
        int pc, nc;
        wr(2, 20);
        repeat (90) @(negedge clk);
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            if (prev && pwm_p[0] != pp_s) break;
            prev = (pwm_p[0] == pp_s);
        end
        wr(2, 0);
        check("R9", "pos stays off after mid-sweep write", int'(pwm_p[0] == pp_s), 0);
        repeat (90) @(negedge clk);
        measure(0, 80, pc, nc);
        check("R9", "new duty after turn, pos count", pc, 80);
    endtask

    task automatic t_ext_clear();
        int pc, nc;
        wr(2, 20);
        repeat (90) @(negedge clk);
        set_ctrl(1, 1, 1, 1);
        ext_clr = 1'b1;
        repeat (3) @(negedge clk);
        measure(0, 80, pc, nc);
        check("R10", "held clear pos count", pc, 0);
        check("R10", "held clear neg count", nc, 80);
        set_ctrl(1, 1, 1, 0);
        repeat (90) @(negedge clk);
        measure(0, 80, pc, nc);
        check("R10", "clear disabled pos count", pc, exp_pos(20, 40, 3));
        ext_clr = 1'b0;
    endtask

    task automatic t_disable();
        set_ctrl(0, 1, 0, 0);
        check("R2", "stopped pwm_p", int'(pwm_p), 0);
        check("R2", "stopped pwm_n", int'(pwm_n), 7);
        check("R7", "overlap cycles, whole run", overlap_cnt, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle_polarity();
        t_mid_duties();
        t_gap();
        t_extremes();
        t_active_low();
        t_buffer_transfer();
        t_ext_clear();
        t_disable();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            vec++;
            bad++;
            $display("FAIL watchdog (all requirements): actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
            $finish;
        end
    end
endmodule